// File: doc/BRIEF.md
# Byte-Lane Instruction Line Buffer

This block holds a set of instruction lines, 32 lines of 16 bytes by default, and hands them to a downstream decoder one byte lane at a time. Each of the 16 lanes is its own small queue with its own valid/ready handshake. A consumer can therefore take byte 3 of a line while byte 9 of an older line is still waiting. Every stored byte carries three marker bits next to its 8 data bits: a used flag, a branch-start flag and a branch-target flag. The buffer passes them through unchanged, and the stage that fills the buffer computes them.

Lines arrive one bit per clock through a scan-style serial input. The lanes present data only after the whole buffer has been filled. Three read modes are available. In normal mode each lane empties once. In recirculating mode every byte taken is put back at the tail of its lane, which gives an endless repeating stream. In frozen mode the head entry is shown over and over. The two looping modes feed a decoder continuously during throughput and power measurements.

Top module: `lane_line_fifo`

## Requirements
- R1: After reset no lane presents valid, the read mode is normal and the buffer is empty.
- R2: A line is 176 serial bits. The first bit shifted in is bit 0 of lane 0. Lane k takes bits 11k to 11k+10 of the line. Within a lane entry, bits [7:0] are the data byte, bit 8 is the used flag, bit 9 is the branch flag and bit 10 is the target flag. Lines are stored in the order they are loaded.
- R3: No lane presents valid while fewer than 32 lines have been loaded. In the cycle after the last bit of the 32nd line, every lane presents valid with line 0.
- R4: In normal mode (mode code 00) a lane advances by one entry on each cycle in which it is both valid and ready, independent of the other lanes. After 32 transfers that lane drops valid.
- R5: The used, branch and target flag bits come out of each lane exactly as they were loaded.
- R6: Serial input bits presented while the buffer is filled are discarded and do not shift into a later line.
- R7: One cycle after every lane has taken all 32 entries, the buffer returns to empty and accepts a new serial load.
- R8: In recirculating mode (mode code 01) a transfer advances the lane without consuming the entry. After line 31 the lane continues at line 0 and never drops valid.
- R9: In frozen mode (mode code 10) a lane keeps presenting the same entry across transfers. When the lane leaves frozen mode it continues from that same entry.
- R10: A requested mode takes effect only after a cycle in which no lane transfers. A request for the reserved code 11 is ignored and the previous mode stays in force.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| scan_en | input | 1 | Serial load strobe, one bit per cycle |
| scan_bit | input | 1 | Serial load data bit |
| mode_req | input | 2 | Requested read mode: 00 normal, 01 recirculate, 10 frozen, 11 reserved |
| lane_rdy | input | 16 | Per-lane consumer ready |
| lane_vld | output | 16 | Per-lane entry valid |
| lane_data | output | 176 | Per-lane entries, lane k in bits 11k+10 down to 11k |

## Verification
Two functions can fall in the same cycle: a mode request and a byte transfer on some lane. When they do, the request must be held off. The bench provokes this by raising a frozen request while all lanes stay ready, then dropping ready for one cycle. A bench model keeps its own per-lane pointers and counts, and the outputs are compared against it on every cycle. The model shows whether the lanes kept advancing under the pending request and began repeating only after the idle cycle. Random readiness combined with random mode requests, including the reserved code, produces many more such collisions.

// File: rtl/lif_pkg.sv
package lif_pkg;

  typedef enum logic [1:0] {
    MODE_NORMAL = 2'b00,
    MODE_RECIRC = 2'b01,
    MODE_FROZEN = 2'b10,
    MODE_RSVD   = 2'b11
  } lif_mode_e;

  // entry layout: [7:0] byte, [8] used, [9] branch, [10] target
  localparam int FLAG_USED   = 8;
  localparam int FLAG_BRANCH = 9;
  localparam int FLAG_TARGET = 10;

  // a request is taken only on a quiet cycle and never for the reserved code
  function automatic logic mode_accept(input logic [1:0] req, input logic busy);
    return !busy && (req != 2'b11);
  endfunction

endpackage

// File: rtl/lif_loader.sv
module lif_loader #(
  parameter int LANES = 16,
  parameter int DEPTH = 32,
  parameter int EW    = 11,
  localparam int LINE_W = LANES * EW,
  localparam int BW     = $clog2(LINE_W),
  localparam int PW     = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scan_en,
  input  logic              scan_bit,
  input  logic              restart,
  output logic              line_wr,
  output logic [PW-1:0]     wr_ptr,
  output logic [LINE_W-1:0] line_bits,
  output logic              filled
);

  logic [LINE_W-1:0] sr;
  logic [BW-1:0]     bit_cnt;
  logic              accept;

  assign accept    = scan_en && !filled;
  assign line_wr   = accept && (bit_cnt == BW'(LINE_W - 1));
  assign line_bits = {scan_bit, sr[LINE_W-1:1]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sr      <= '0;
      bit_cnt <= '0;
      wr_ptr  <= '0;
      filled  <= 1'b0;
    end else begin
      if (accept) begin
        sr      <= line_bits;
        bit_cnt <= line_wr ? '0 : bit_cnt + BW'(1);
      end
      if (line_wr)
        wr_ptr <= (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + PW'(1);
      if (restart)
        filled <= 1'b0;
      else if (line_wr && wr_ptr == PW'(DEPTH - 1))
        filled <= 1'b1;
    end
  end

  // R6: while filled the serial position never moves
  a_r6_scan_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    filled |=> $stable(bit_cnt) && $stable(sr));

  // R3: the buffer becomes filled exactly as the write pointer wraps
  a_r3_fill_at_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(filled) |-> (wr_ptr == '0) && (bit_cnt == '0));

endmodule

// File: rtl/lif_mode_ctl.sv
module lif_mode_ctl
  import lif_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode_req,
  input  logic       busy,
  output lif_mode_e  mode
);

  always_ff @(posedge clk) begin
    if (!rst_n)
      mode <= MODE_NORMAL;
    else if (mode_accept(mode_req, busy))
      mode <= lif_mode_e'(mode_req);
  end

  // R10: a transfer cycle blocks any mode change
  a_r10_hold_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(mode));

  // R10: the reserved code is never adopted
  a_r10_no_reserved: assert property (@(posedge clk) disable iff (!rst_n)
    mode != MODE_RSVD);

endmodule

// File: rtl/lif_lane.sv
module lif_lane
  import lif_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int EW    = 11,
  localparam int PW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [PW-1:0] wr_ptr,
  input  logic [EW-1:0] wr_entry,
  input  logic          filled,
  input  logic          restart,
  input  lif_mode_e     mode,
  input  logic          rdy,
  output logic          vld,
  output logic [EW-1:0] entry,
  output logic          fire,
  output logic          drained
);

  localparam logic [CW-1:0] ALL_TAKEN = CW'(DEPTH);

  function automatic logic [PW-1:0] next_ptr(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  logic [EW-1:0] mem [DEPTH];
  logic [PW-1:0] rd_ptr;
  logic [CW-1:0] taken;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_ptr] <= wr_entry;
  end

  assign drained = (taken == ALL_TAKEN);
  assign vld     = filled && !(mode == MODE_NORMAL && drained);
  assign fire    = vld && rdy;
  assign entry   = mem[rd_ptr];

  // the lane is full while reading, so the recirculation slot is the read slot
  always_ff @(posedge clk) begin
    if (!rst_n || restart) begin
      rd_ptr <= '0;
      taken  <= '0;
    end else if (fire) begin
      if (mode != MODE_FROZEN) rd_ptr <= next_ptr(rd_ptr);
      if (mode == MODE_NORMAL) taken  <= taken + CW'(1);
    end
  end

  // R4: consumption count never passes the depth
  a_r4_taken_bound: assert property (@(posedge clk) disable iff (!rst_n)
    taken <= ALL_TAKEN);

  // R4: a normal transfer consumes exactly one entry
  a_r4_normal_consume: assert property (@(posedge clk) disable iff (!rst_n)
    fire && mode == MODE_NORMAL && !restart |=> taken == $past(taken) + CW'(1));

  // R8: a recirculating transfer consumes nothing
  a_r8_recirc_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    fire && mode == MODE_RECIRC && !restart |=> $stable(taken));

  // R9: a frozen transfer leaves the read position in place
  a_r9_frozen_holds: assert property (@(posedge clk) disable iff (!rst_n)
    fire && mode == MODE_FROZEN && !restart |=> $stable(rd_ptr));

endmodule

// File: rtl/lane_line_fifo.sv
module lane_line_fifo
  import lif_pkg::*;
#(
  parameter int LANES = 16,
  parameter int DEPTH = 32,
  parameter int EW    = 11,
  localparam int LINE_W = LANES * EW,
  localparam int PW     = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scan_en,
  input  logic              scan_bit,
  input  logic [1:0]        mode_req,
  input  logic [LANES-1:0]  lane_rdy,
  output logic [LANES-1:0]  lane_vld,
  output logic [LINE_W-1:0] lane_data
);

  logic              line_wr;
  logic [PW-1:0]     wr_ptr;
  logic [LINE_W-1:0] line_bits;
  logic              filled;
  logic              restart;
  logic              busy;
  logic [LANES-1:0]  lane_fire;
  logic [LANES-1:0]  lane_drained;
  lif_mode_e         mode;

  assign busy    = |lane_fire;
  assign restart = filled && (&lane_drained);

  lif_loader #(.LANES(LANES), .DEPTH(DEPTH), .EW(EW)) u_loader (
    .clk       (clk),
    .rst_n     (rst_n),
    .scan_en   (scan_en),
    .scan_bit  (scan_bit),
    .restart   (restart),
    .line_wr   (line_wr),
    .wr_ptr    (wr_ptr),
    .line_bits (line_bits),
    .filled    (filled)
  );

  lif_mode_ctl u_mode (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode_req (mode_req),
    .busy     (busy),
    .mode     (mode)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    lif_lane #(.DEPTH(DEPTH), .EW(EW)) u_lane (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (line_wr),
      .wr_ptr   (wr_ptr),
      .wr_entry (line_bits[g*EW +: EW]),
      .filled   (filled),
      .restart  (restart),
      .mode     (mode),
      .rdy      (lane_rdy[g]),
      .vld      (lane_vld[g]),
      .entry    (lane_data[g*EW +: EW]),
      .fire     (lane_fire[g]),
      .drained  (lane_drained[g])
    );
  end

  // R7: a full drain empties the buffer on the following cycle
  a_r7_restart_empties: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !filled && lane_vld == '0);

  // R3: no lane offers data while the buffer is being loaded
  a_r3_quiet_loading: assert property (@(posedge clk) disable iff (!rst_n)
    line_wr |-> lane_vld == '0);

endmodule

// File: tb/lane_line_fifo_bench.sv
module lane_line_fifo_bench;

  localparam int LN = 16;
  localparam int DP = 32;
  localparam int EW = 11;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             scan_en = 1'b0;
  logic             scan_bit = 1'b0;
  logic [1:0]       mode_req = 2'b00;
  logic [LN-1:0]    lane_rdy = '0;
  logic [LN-1:0]    lane_vld;
  logic [LN*EW-1:0] lane_data;

  lane_line_fifo u_lane_line_fifo (
    .clk(clk), .rst_n(rst_n), .scan_en(scan_en), .scan_bit(scan_bit),
    .mode_req(mode_req), .lane_rdy(lane_rdy),
    .lane_vld(lane_vld), .lane_data(lane_data)
  );

  always #2 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // bench model
  logic [EW-1:0] m_mem [DP][LN];
  logic [EW-1:0] pend [LN];
  int m_ptr [LN];
  int m_cnt [LN];
  int m_mode, m_filled, m_wr, m_bits;
  logic [1:0] cur_req = 2'b00;

  function automatic bit exp_vld(input int l);
    return (m_filled != 0) && !(m_mode == 0 && m_cnt[l] == DP);
  endfunction

  task automatic check(input string tag);
    bit bad = 0;
    checks++;
    for (int l = 0; l < LN; l++) begin
      if (!bad && lane_vld[l] !== exp_vld(l)) begin
        bad = 1;
        $display("FAIL %s lane %0d valid act %b exp %b", tag, l, lane_vld[l], exp_vld(l));
      end
      if (!bad && exp_vld(l) && lane_data[l*EW +: EW] !== m_mem[m_ptr[l]][l]) begin
        bad = 1;
        $display("FAIL %s lane %0d data act %h exp %h", tag, l,
                 lane_data[l*EW +: EW], m_mem[m_ptr[l]][l]);
      end
    end
    if (bad) fails++;
  endtask

  task automatic check_flags(input string tag);
    bit bad = 0;
    checks++;
    for (int l = 0; l < LN; l++)
      if (!bad && lane_data[l*EW+8 +: 3] !== m_mem[m_ptr[l]][l][10:8]) begin
        bad = 1;
        $display("FAIL %s lane %0d flags act %b exp %b", tag, l,
                 lane_data[l*EW+8 +: 3], m_mem[m_ptr[l]][l][10:8]);
      end
    if (bad) fails++;
  endtask

  task automatic check_all_vld(input string tag, input logic [LN-1:0] exp);
    checks++;
    if (lane_vld !== exp) begin
      fails++;
      $display("FAIL %s valid vector act %h exp %h", tag, lane_vld, exp);
    end
  endtask

  // one clock: drive at negedge, step model at posedge, compare at next negedge
  task automatic tick(input logic se, input logic sb, input logic [LN-1:0] r,
                      input logic [1:0] m, input string tag);
    bit fire [LN];
    bit any = 0;
    bit all_dr = 1;
    scan_en = se; scan_bit = sb; lane_rdy = r; mode_req = m;
    for (int l = 0; l < LN; l++) begin
      fire[l] = exp_vld(l) && r[l];
      if (fire[l]) any = 1;
      if (m_cnt[l] != DP) all_dr = 0;
    end
    @(posedge clk);
    if (m_filled != 0 && all_dr) begin
      m_filled = 0;
      for (int l = 0; l < LN; l++) begin m_ptr[l] = 0; m_cnt[l] = 0; end
    end else begin
      for (int l = 0; l < LN; l++)
        if (fire[l]) begin
          if (m_mode != 2) m_ptr[l] = (m_ptr[l] + 1) % DP;
          if (m_mode == 0) m_cnt[l]++;
        end
      if (m_filled == 0 && se) begin
        m_bits++;
        if (m_bits == LN*EW) begin
          m_bits = 0;
          for (int l = 0; l < LN; l++) m_mem[m_wr][l] = pend[l];
          m_wr = (m_wr + 1) % DP;
          if (m_wr == 0) m_filled = 1;
        end
      end
    end
    if (!any && m != 2'b11) m_mode = int'(m);
    @(negedge clk);
    check(tag);
  endtask

  task automatic load_buffer(input string tag);
    for (int ln = 0; ln < DP; ln++) begin
      for (int l = 0; l < LN; l++) pend[l] = EW'($urandom);
      if (ln == 0) pend[3] = {3'b101, 8'h5a};
      for (int l = 0; l < LN; l++)
        for (int b = 0; b < EW; b++) begin
          if ($urandom % 8 == 0) tick(1'b0, 1'b1, '0, cur_req, tag);
          tick(1'b1, pend[l][b], '0, cur_req, tag);
        end
    end
  endtask

  task automatic drain_random(input string tag);
    for (int i = 0; i < 4000 && m_filled != 0; i++)
      tick(1'b0, 1'b0, LN'($urandom), 2'b00, tag);
  endtask

  initial begin
    #600000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    m_mode = 0; m_filled = 0; m_wr = 0; m_bits = 0;
    for (int l = 0; l < LN; l++) begin m_ptr[l] = 0; m_cnt[l] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1");
    check_all_vld("R1", '0);

    // first fill, then look at line 0 as loaded
    load_buffer("R3");
    check_all_vld("R3", '1);
    check("R2");
    check_flags("R5");

    // serial bits while filled must be dropped
    for (int i = 0; i < 60; i++) tick(1'b1, 1'($urandom), '0, 2'b00, "R6");

    drain_random("R4");
    check_all_vld("R7", '0);

    // refill; misalignment from R6 bits would show here
    load_buffer("R7");
    check("R6");
    check_flags("R5");

    // frozen requested while every lane transfers: must be held off
    for (int i = 0; i < 5; i++) tick(1'b0, 1'b0, '1, 2'b10, "R10");
    tick(1'b0, 1'b0, '0, 2'b10, "R10");
    for (int i = 0; i < 6; i++) tick(1'b0, 1'b0, '1, 2'b10, "R9");
    tick(1'b0, 1'b0, '0, 2'b01, "R10");
    for (int i = 0; i < 400; i++) tick(1'b0, 1'b0, LN'($urandom), 2'b01, "R8");
    tick(1'b0, 1'b0, '0, 2'b11, "R10");
    for (int i = 0; i < 40; i++) tick(1'b0, 1'b0, '1, 2'b11, "R10");
    tick(1'b0, 1'b0, '0, 2'b10, "R9");
    for (int i = 0; i < 8; i++) tick(1'b0, 1'b0, LN'($urandom), 2'b10, "R9");
    tick(1'b0, 1'b0, '0, 2'b00, "R9");
    drain_random("R4");

    // mixed random modes
    load_buffer("R3");
    for (int i = 0; i < 2000; i++) begin
      if ($urandom % 16 == 0) cur_req = 2'($urandom);
      tick(1'b0, 1'b0, LN'($urandom), cur_req, "R10");
    end
    cur_req = 2'b00;
    for (int i = 0; i < 4 && m_mode != 0; i++) tick(1'b0, 1'b0, '0, 2'b00, "R10");
    drain_random("R4");
    check_all_vld("R7", '0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule